// File: doc/BRIEF.md
# Shared-Bus Busy Arbiter for Four Hosts

This block sits at the target end of one asynchronous parallel memory bus that four host processors share. Each host drives its own active-low transfer-active strobe and watches its own status line. While a host's line reads low, that host may begin a transfer. There is no request wire. The block learns who owns the bus from the strobe of the host that starts first. It then raises the status line of each of the other three hosts, and it keeps the owner's own line low until that transfer is over.

All host strobes and the write strobe are brought into the block clock domain through two-flop synchronizers. If two hosts are first seen in the same cycle, a fixed priority picks one owner. When a host that is not the owner starts while the bus is locked, a sticky collision record is kept until software clears it. A small register file behind the bus gives the arbitration something to protect: writes reach it only while an owner is recorded.

Top module: `hostbus_arbiter`

## Requirements
- R1: After reset all four status lines are low, `bus_busy` is 0, `owner` is 0, `coll_flag` is 0 and `coll_host` is 0. Whenever `bus_busy` is 0, `owner` reads 0.
- R2: A host strobe `host_cs_n[i]` that goes low is used by the arbiter only after two clock edges. No status line changes at the first edge after the strobe falls.
- R3: `busy_line[i]` = 1 means busy for host i. From the second edge after an idle-bus start by host i, every other host's line is 1 and line i stays 0. From the third edge `bus_busy` is 1 and `owner` = i.
- R4: If several strobes are first seen in the same cycle, the lowest-numbered host becomes owner. All losers' lines rise in that same cycle, and no collision is recorded.
- R5: Once the owner's synchronized strobe has read inactive for two consecutive cycles, the next edge clears `bus_busy` and `owner`. All four lines are then low, provided no other strobe is active.
- R6: An owner strobe that is inactive for only one synchronized cycle and then active again keeps ownership.
- R7: A newly asserted strobe from a non-owner while `bus_busy` is 1 sets `coll_flag` and loads that host's index into `coll_host` one edge after it is seen. The owner and the status lines do not change.
- R8: `coll_flag` and `coll_host` are sticky, and the first recorded index is kept. A one-cycle `coll_clr` pulse clears both to 0. If a new collision arrives in the same cycle as `coll_clr`, the flag stays set and the new index is recorded.
- R9: A write takes effect when the synchronized `bus_wr_n` returns high (the end of the strobe). It stores `bus_wdata` at `bus_addr` only if `bus_busy` is 1 at that point. Otherwise the write is ignored.
- R10: `bus_rdata` shows the register selected by `bus_addr` without any clock delay. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 4 | Per-host transfer-active strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Shared write strobe, active low, asynchronous |
| bus_addr | input | AW | Shared register address |
| bus_wdata | input | DW | Shared write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| coll_clr | input | 1 | One-cycle pulse that clears the collision record |
| busy_line | output | 4 | Per-host status, 1 = bus held by another host |
| owner | output | 2 | Index of the current owner |
| bus_busy | output | 1 | An owner is recorded |
| coll_flag | output | 1 | Sticky collision indicator |
| coll_host | output | 2 | Index of the first colliding host |

## Verification
A bad owner register shows up in the same sample as a wrong pattern on `busy_line`, because the lines are decoded straight from the owner. A stuck or miscounted release counter appears within two cycles of the owner dropping its strobe: the lines are freed too early, too late, or after a single-cycle glitch. A corrupt collision record is visible on `coll_flag` and `coll_host` one edge after the intruding strobe is synchronized. Register-file gating errors remain hidden until a read-back, so the bench reads back after each protected and each unprotected write.

// File: rtl/hostbus_arbiter.sv
`timescale 1ns/1ps
module hostbus_arbiter #(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    host_cs_n,
  input  logic          bus_wr_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          coll_clr,
  output logic [3:0]    busy_line,
  output logic [1:0]    owner,
  output logic          bus_busy,
  output logic          coll_flag,
  output logic [1:0]    coll_host
);
  localparam int DEPTH = 1 << AW;

  logic [3:0]    cs_s1, cs_s2, act, act_q, rise, intruders;
  logic [1:0]    wr_s;
  logic          wr_q, rel_cnt;
  logic [1:0]    win;
  logic [DW-1:0] regs [DEPTH];

  function automatic logic [1:0] lowest(input logic [3:0] v);
    return v[0] ? 2'd0 : v[1] ? 2'd1 : v[2] ? 2'd2 : 2'd3;
  endfunction

  assign act       = ~cs_s2;
  assign rise      = act & ~act_q;
  assign win       = lowest(act);
  assign busy_line = bus_busy ? ~(4'b0001 << owner)
                   : (|act) ? ~(4'b0001 << win) : 4'b0000;
  assign intruders = bus_busy ? (rise & ~(4'b0001 << owner)) : 4'b0000;
  assign bus_rdata = regs[bus_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s1 <= 4'hF;
      cs_s2 <= 4'hF;
      act_q <= 4'h0;
      wr_s  <= 2'b11;
      wr_q  <= 1'b1;
    end else begin
      cs_s1 <= host_cs_n;
      cs_s2 <= cs_s1;
      act_q <= act;
      wr_s  <= {wr_s[0], bus_wr_n};
      wr_q  <= wr_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy <= 1'b0;
      owner    <= 2'd0;
      rel_cnt  <= 1'b0;
    end else if (!bus_busy) begin
      rel_cnt <= 1'b0;
      if (|act) begin
        bus_busy <= 1'b1;
        owner    <= win;
      end
    end else if (!act[owner]) begin
      if (rel_cnt) begin
        bus_busy <= 1'b0;
        owner    <= 2'd0;
        rel_cnt  <= 1'b0;
      end else begin
        rel_cnt <= 1'b1;
      end
    end else begin
      rel_cnt <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_flag <= 1'b0;
      coll_host <= 2'd0;
    end else if ((|intruders) && (!coll_flag || coll_clr)) begin
      coll_flag <= 1'b1;
      coll_host <= lowest(intruders);
    end else if (coll_clr) begin
      coll_flag <= 1'b0;
      coll_host <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_s[1] && !wr_q && bus_busy) begin
      regs[bus_addr] <= bus_wdata;
    end
  end
endmodule

module hostbus_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] busy_line,
  input logic [1:0] owner,
  input logic       bus_busy,
  input logic       coll_flag,
  input logic [1:0] coll_host,
  input logic       coll_clr
);
  p_idle_owner_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> owner == 2'd0);

  p_owner_line_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> busy_line[owner] == 1'b0);

  p_others_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> $countones(busy_line) == 3);

  p_owner_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_busy) && bus_busy) |-> owner == $past(owner));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !coll_clr) |=> coll_flag);

  p_index_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(coll_flag) && coll_flag && !$past(coll_clr)) |-> $stable(coll_host));
endmodule

bind hostbus_arbiter hostbus_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_line(busy_line), .owner(owner),
  .bus_busy(bus_busy), .coll_flag(coll_flag), .coll_host(coll_host),
  .coll_clr(coll_clr)
);

// File: tb/sim_hostbus_arbiter.sv
`timescale 1ns/1ps
module sim_hostbus_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_cs_n = 4'hF;
  logic        bus_wr_n = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        coll_clr = 1'b0;
  logic [3:0]  busy_line;
  logic [1:0]  owner, coll_host;
  logic        bus_busy, coll_flag;

  always #2 clk = ~clk;

  hostbus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .coll_clr(coll_clr), .busy_line(busy_line), .owner(owner),
    .bus_busy(bus_busy), .coll_flag(coll_flag), .coll_host(coll_host)
  );

  typedef struct {
    string       tag;
    logic [9:0]  st;
    bit          rd_en;
    logic [15:0] rd;
  } item_t;

  item_t sbq[$];
  item_t it;
  int vectors = 0;
  int errs = 0;
  bit done = 0;

  function automatic logic [9:0] st(input logic [3:0] b, input logic bb,
                                    input logic [1:0] o, input logic cf,
                                    input logic [1:0] ch);
    return {b, bb, o, cf, ch};
  endfunction

  localparam logic [9:0] IDLE = 10'b0;

  always @(posedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      vectors++;
      if ({busy_line, bus_busy, owner, coll_flag, coll_host} !== it.st) begin
        errs++;
        $display("FAIL %s: state actual %b expected %b", it.tag,
                 {busy_line, bus_busy, owner, coll_flag, coll_host}, it.st);
      end
      if (it.rd_en && bus_rdata !== it.rd) begin
        errs++;
        $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.rd);
      end
    end
  end

  task automatic hold(input string tag, input logic [9:0] s, input int n);
    for (int k = 0; k < n; k++) begin
      sbq.push_back('{tag, s, 1'b0, 16'h0});
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input string tag, input logic [9:0] s,
                          input logic [1:0] a, input logic [15:0] d);
    bus_addr = a;
    sbq.push_back('{tag, s, 1'b1, d});
    @(negedge clk);
  endtask

  task automatic bus_write(input string tag, input logic [9:0] s,
                           input logic [1:0] a, input logic [15:0] d);
    bus_addr = a;
    bus_wdata = d;
    bus_wr_n = 1'b0;
    hold(tag, s, 3);
    bus_wr_n = 1'b1;
    hold(tag, s, 4);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [9:0] own2, own1, own0;
    own2 = st(4'b1011, 1, 2'd2, 0, 2'd0);
    own1 = st(4'b1101, 1, 2'd1, 0, 2'd0);
    own0 = st(4'b1110, 1, 2'd0, 0, 2'd0);

    repeat (3) @(negedge clk);
    hold("R1 in reset", IDLE, 1);
    rst_n = 1'b1;
    hold("R1 after reset", IDLE, 2);
    read_chk("R10 reset reg", IDLE, 2'd3, 16'h0);

    host_cs_n[2] = 1'b0;
    hold("R2 first edge", IDLE, 1);
    hold("R3 lines", st(4'b1011, 0, 2'd0, 0, 2'd0), 1);
    hold("R3 owner", own2, 3);

    bus_write("R9 owned write", own2, 2'd1, 16'hA5A5);
    read_chk("R9 readback", own2, 2'd1, 16'hA5A5);
    read_chk("R10 other addr", own2, 2'd0, 16'h0);

    host_cs_n[2] = 1'b1;
    hold("R6 glitch", own2, 1);
    host_cs_n[2] = 1'b0;
    hold("R6 kept", own2, 6);

    host_cs_n[0] = 1'b0;
    hold("R7 pre", own2, 2);
    hold("R7 flag", st(4'b1011, 1, 2'd2, 1, 2'd0), 2);
    host_cs_n[3] = 1'b0;
    hold("R8 first kept", st(4'b1011, 1, 2'd2, 1, 2'd0), 4);
    host_cs_n[0] = 1'b1;
    host_cs_n[3] = 1'b1;
    hold("R8 sticky", st(4'b1011, 1, 2'd2, 1, 2'd0), 3);
    coll_clr = 1'b1;
    hold("R8 clear", own2, 1);
    coll_clr = 1'b0;
    hold("R8 cleared", own2, 2);

    host_cs_n[2] = 1'b1;
    hold("R5 still held", own2, 3);
    hold("R5 freed", IDLE, 2);

    bus_write("R9 free write", IDLE, 2'd1, 16'h1234);
    read_chk("R9 ignored", IDLE, 2'd1, 16'hA5A5);
    bus_write("R9 free write2", IDLE, 2'd2, 16'h00FF);
    read_chk("R9 ignored2", IDLE, 2'd2, 16'h0);

    host_cs_n[1] = 1'b0;
    host_cs_n[3] = 1'b0;
    hold("R4 first edge", IDLE, 1);
    hold("R4 lines", st(4'b1101, 0, 2'd0, 0, 2'd0), 1);
    hold("R4 owner", own1, 3);
    host_cs_n[1] = 1'b1;
    host_cs_n[3] = 1'b1;
    hold("R5 tie held", own1, 3);
    hold("R5 tie freed", IDLE, 2);

    host_cs_n[0] = 1'b0;
    hold("R2 host0", IDLE, 1);
    hold("R3 host0 lines", st(4'b1110, 0, 2'd0, 0, 2'd0), 1);
    hold("R3 host0 owner", own0, 2);
    host_cs_n[2] = 1'b0;
    hold("R7 pre2", own0, 2);
    hold("R7 host2", st(4'b1110, 1, 2'd0, 1, 2'd2), 2);
    host_cs_n[1] = 1'b0;
    hold("R8 pre", st(4'b1110, 1, 2'd0, 1, 2'd2), 2);
    coll_clr = 1'b1;
    hold("R8 clear+new", st(4'b1110, 1, 2'd0, 1, 2'd1), 1);
    coll_clr = 1'b0;
    hold("R8 new kept", st(4'b1110, 1, 2'd0, 1, 2'd1), 3);
    coll_clr = 1'b1;
    hold("R8 clear2", own0, 1);
    coll_clr = 1'b0;
    host_cs_n = 4'hF;
    hold("R5 last held", own0, 3);
    hold("R5 last freed", IDLE, 2);
    hold("R1 idle", IDLE, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule